// File: doc/BRIEF.md
# Embedded Controller Message Length Decoder

This block sits behind a byte receiver that collects messages written by an embedded controller. It watches each byte as it arrives and counts them. From the first byte, and when needed the second, it works out how many bytes a complete message must hold. When the end-of-transfer strobe arrives, it decides whether the message came in whole. For a whole message it also reports how software should route it.

The top bit of the first byte tells an unsolicited event apart from a reply to an earlier request. Events carry a two-bit size class in bits 6:5 of that byte. Two classes are fixed lengths. A third class means the length is variable and comes from a count byte. Replies always take their length from the count byte. The per-transfer verdict is held for one cycle on registered outputs. A completed reply also raises a pulse, so that the request waiting on it can be retired.

Top module: `ec_msg_len_decoder`

## Requirements
- R1: After reset, res_valid, res_complete, res_event, res_err, res_sysevt and res_done are 0, res_type is 0, and exp_len is 0.
- R2: While no byte of the current transfer has been received, exp_len is 0.
- R3: For an event (byte 0 bit 7 = 1), bits 6:5 of byte 0 select the length: 00 gives exp_len 2, 01 gives exp_len 3, and 11 gives exp_len 0.
- R4: For a reply (byte 0 bit 7 = 0), or for an event with size bits 10, exp_len is byte 1 plus 2. If byte 1 has not yet arrived, it counts as 0.
- R5: One cycle after xfer_end, res_valid is 1 for exactly one cycle. In that cycle, res_complete is 1 only when the received byte count is non-zero and equals exp_len.
- R6: In the result cycle, res_event equals byte 0 bit 7, and res_type equals byte 0 AND 0x8F.
- R7: res_err is 1 only for a complete reply whose byte at index 3 is non-zero. An event with a non-zero byte 3 never raises it.
- R8: res_sysevt is 1 only for an event whose byte 0 low nibble equals 5.
- R9: res_done pulses for one cycle together with res_valid, and only for a complete reply. It never pulses for an event or for an incomplete transfer.
- R10: After xfer_end, the byte count and the captured header bytes restart from zero, so exp_len reads 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | A received byte is present on rx_byte |
| rx_byte | input | 8 | Received byte |
| xfer_end | input | 1 | End-of-transfer strobe |
| exp_len | output | 9 | Expected message length for the bytes seen so far |
| res_valid | output | 1 | Result cycle marker |
| res_complete | output | 1 | Message arrived whole |
| res_event | output | 1 | Message is an event rather than a reply |
| res_type | output | 8 | Dispatch type code |
| res_err | output | 1 | Complete reply reporting failure |
| res_sysevt | output | 1 | Event of the system class |
| res_done | output | 1 | Complete reply retires a pending request |

## Verification
The assertions assume that rx_valid and xfer_end are never high in the same cycle. They also assume that a transfer never exceeds the counter's saturation limit. The bench drives each byte in its own cycle and holds rx_valid low before it raises the end strobe. Messages stay well under the limit, and empty, short and over-long transfers are all exercised within those bounds.

// File: rtl/ec_msg_len_decoder.sv
module ec_msg_len_decoder #(
  parameter int CNT_W = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       xfer_end,
  output logic [8:0] exp_len,
  output logic       res_valid,
  output logic       res_complete,
  output logic       res_event,
  output logic [7:0] res_type,
  output logic       res_err,
  output logic       res_sysevt,
  output logic       res_done
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [7:0] hdr0, hdr1, hdr3;
  logic       is_evt;
  logic [1:0] size_cls;
  logic       whole;

  assign is_evt   = hdr0[7];
  assign size_cls = hdr0[6:5];

  always_ff @(posedge clk) begin
    if (!rst_n || xfer_end) begin
      cnt  <= '0;
      hdr0 <= '0;
      hdr1 <= '0;
      hdr3 <= '0;
    end else if (rx_valid) begin
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(0)) hdr0 <= rx_byte;
      if (cnt == CNT_W'(1)) hdr1 <= rx_byte;
      if (cnt == CNT_W'(3)) hdr3 <= rx_byte;
    end
  end

  always_comb begin
    if (cnt == '0)
      exp_len = '0;
    else if (!is_evt || size_cls == 2'b10)
      exp_len = {1'b0, hdr1} + 9'd2;
    else if (size_cls == 2'b00)
      exp_len = 9'd2;
    else if (size_cls == 2'b01)
      exp_len = 9'd3;
    else
      exp_len = 9'd0;
  end

  assign whole = (cnt != '0) && (32'(cnt) == 32'(exp_len));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid    <= 1'b0;
      res_complete <= 1'b0;
      res_event    <= 1'b0;
      res_type     <= '0;
      res_err      <= 1'b0;
      res_sysevt   <= 1'b0;
      res_done     <= 1'b0;
    end else begin
      res_valid    <= xfer_end;
      res_complete <= xfer_end && whole;
      res_event    <= xfer_end && is_evt;
      res_type     <= xfer_end ? (hdr0 & 8'h8F) : 8'h00;
      res_err      <= xfer_end && whole && !is_evt && (hdr3 != 8'h00);
      res_sysevt   <= xfer_end && is_evt && (hdr0[3:0] == 4'd5);
      res_done     <= xfer_end && whole && !is_evt;
    end
  end
endmodule

module ec_msg_len_decoder_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic             xfer_end,
  input logic [8:0]       exp_len,
  input logic             res_valid,
  input logic             res_complete,
  input logic             res_event,
  input logic [7:0]       res_type,
  input logic             res_err,
  input logic             res_sysevt,
  input logic             res_done,
  input logic [CNT_W-1:0] cnt,
  input logic [7:0]       hdr0
);
  p_no_overlap_in: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && xfer_end));
  p_empty_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> (exp_len == 9'd0));
  p_fixed_two_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && hdr0[7] && hdr0[6:5] == 2'b00) |-> (exp_len == 9'd2));
  p_fixed_three_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && hdr0[7] && hdr0[6:5] == 2'b01) |-> (exp_len == 9'd3));
  p_result_follows_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> res_valid);
  p_result_needs_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(xfer_end));
  p_type_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_type & 8'h70) == 8'h00);
  p_err_reply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_err |-> (res_complete && !res_event));
  p_sys_is_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_sysevt |-> (res_event && res_type[3:0] == 4'd5));
  p_done_reply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> (res_valid && res_complete && !res_event));
  p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_end |=> (exp_len == 9'd0));
endmodule

bind ec_msg_len_decoder ec_msg_len_decoder_chk #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/tb_ec_msg_len_decoder.sv
module tb_ec_msg_len_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic xfer_end = 1'b0;
  logic [8:0] exp_len;
  logic res_valid, res_complete, res_event, res_err, res_sysevt, res_done;
  logic [7:0] res_type;

  int checks = 0;
  int fails = 0;
  logic [7:0] msg [0:15];

  always #10 clk = ~clk;

  ec_msg_len_decoder dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_len(input int n);
    int l;
    if (n == 0) return 0;
    if (!msg[0][7] || msg[0][6:5] == 2'b10) l = ((n > 1) ? int'(msg[1]) : 0) + 2;
    else if (msg[0][6:5] == 2'b00) l = 2;
    else if (msg[0][6:5] == 2'b01) l = 3;
    else l = 0;
    return l;
  endfunction

  task automatic run_case(input string name, input int n);
    int el, whole, evt, b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1;
      rx_byte  = msg[i];
    end
    @(negedge clk);
    rx_valid = 1'b0;
    el = model_len(n);
    b0 = (n > 0) ? int'(msg[0]) : 0;
    evt = (b0 >> 7) & 1;
    whole = (n != 0 && n == el) ? 1 : 0;
    #1 chk({name, " R2 R3 R4 exp_len"}, int'(exp_len), el);
    xfer_end = 1'b1;
    @(negedge clk);
    xfer_end = 1'b0;
    #1;
    chk({name, " R5 valid"}, int'(res_valid), 1);
    chk({name, " R5 complete"}, int'(res_complete), whole);
    chk({name, " R6 event"}, int'(res_event), evt);
    chk({name, " R6 type"}, int'(res_type), b0 & 8'h8F);
    chk({name, " R7 err"}, int'(res_err),
        (whole == 1 && evt == 0 && n > 3 && msg[3] != 8'h00) ? 1 : 0);
    chk({name, " R8 sysevt"}, int'(res_sysevt), (evt == 1 && (b0 & 15) == 5) ? 1 : 0);
    chk({name, " R9 done"}, int'(res_done), (whole == 1 && evt == 0) ? 1 : 0);
    chk({name, " R10 restart"}, int'(exp_len), 0);
    @(negedge clk);
    #1;
    chk({name, " R5 one-cycle valid"}, int'(res_valid), 0);
    chk({name, " R9 one-cycle done"}, int'(res_done), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 res_done", int'(res_done), 0);
    chk("R1 res_type", int'(res_type), 0);
    chk("R1 R2 exp_len", int'(exp_len), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_events();
    msg[0] = 8'h83; msg[1] = 8'h11;               run_case("ev2", 2);
    msg[0] = 8'hA1; msg[1] = 8'h22; msg[2] = 8'h33; run_case("ev3", 3);
    run_case("ev3 short", 2);
    msg[0] = 8'hE4; msg[1] = 8'h01;               run_case("ev reserved", 2);
    msg[0] = 8'hC2; msg[1] = 8'h03; msg[2] = 8'h01; msg[3] = 8'h09; msg[4] = 8'h02;
    run_case("ev var", 5);
    msg[0] = 8'h85; msg[1] = 8'h00;               run_case("sys ev", 2);
    msg[0] = 8'hC5; msg[1] = 8'h02; msg[2] = 8'h00; msg[3] = 8'h07;
    run_case("ev byte3 ignored", 4);
  endtask

  task automatic t_replies();
    msg[0] = 8'h02; msg[1] = 8'h02; msg[2] = 8'h07; msg[3] = 8'h00;
    run_case("reply ok", 4);
    msg[3] = 8'h05;                               run_case("reply err", 4);
    run_case("reply short", 3);
    msg[0] = 8'h0D; msg[1] = 8'h00; msg[2] = 8'h01;
    run_case("reply long", 3);
    msg[0] = 8'h01;                               run_case("reply one byte", 1);
    run_case("empty", 0);
  endtask

  initial begin
    t_reset();
    t_events();
    t_replies();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule